// File: doc/BRIEF.md
# Bypass Point Output Arbiter with Yield Control

This block sits at one bypass point of an on-chip router. Flits on the bypass channel can leave on the outgoing link without passing through the router's switch. The flits the router itself produces must share that same link. An output multiplexer picks, packet by packet, which of the two sources drives the outgoing channel. The bypass source is primary: it wins whenever it has traffic at a packet boundary. The router-side source is non-primary. It is taken only when the bypass side is idle, and it waits in a small local queue of flits.

A grant, once given, lasts from a packet's head flit to its tail flit, so packets never interleave on the link. A strictly prioritised scheme can leave the non-primary side waiting forever. To prevent that, a counter measures how long queued non-primary traffic has been refused. When that count reaches a threshold set at a port, the block sends one control flit upstream asking the bypass source to yield. The block then holds the bypass input off until one non-primary packet has left.

Top module: `yarb_top`

## Requirements
- R1: When the bypass side owns the output, out_valid, out_data and out_last follow byp_valid, byp_data and byp_last, and byp_ready equals out_ready.
- R2: At a packet boundary with no yield in effect, a valid bypass flit is granted even when non-primary flits are queued.
- R3: When the bypass side is idle at a packet boundary, the oldest queued non-primary flit drives the output.
- R4: A grant lasts from head to tail flit: after a non-tail flit transfers, the same source keeps the output even if it has a bubble and the other side is waiting.
- R5: The non-primary queue holds four flits in arrival order; dir_ready is low exactly when four flits are queued.
- R6: A starvation count measures consecutive cycles in which the queue is non-empty and the non-primary side does not own the output. In the cycle where this count reaches thresh (a thresh of 0 acts as 1), a yield is armed that takes effect in the next cycle.
- R7: Arming a yield raises ctl_valid with ctl_data equal to 16'hA000 (opcode 4'hA in bits 15:12, zero below). ctl_valid stays high until a cycle with ctl_ready high.
- R8: While a yield is in effect and no bypass packet is in flight, byp_ready is low and the non-primary side owns the output. The yield ends when that side's tail flit transfers, and the bypass side may win again in the following cycle.
- R9: Directly after reset, out_valid and ctl_valid are low, dir_ready is high and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thresh | input | 8 | Starvation threshold in cycles |
| byp_valid | input | 1 | Bypass (primary) flit valid |
| byp_data | input | 16 | Bypass flit payload |
| byp_last | input | 1 | Bypass flit is a packet tail |
| byp_ready | output | 1 | Bypass flit accepted |
| dir_valid | input | 1 | Router-side (non-primary) flit valid |
| dir_data | input | 16 | Router-side flit payload |
| dir_last | input | 1 | Router-side flit is a packet tail |
| dir_ready | output | 1 | Non-primary queue has space |
| out_valid | output | 1 | Outgoing flit valid |
| out_data | output | 16 | Outgoing flit payload |
| out_last | output | 1 | Outgoing flit is a packet tail |
| out_ready | input | 1 | Outgoing link accepts the flit |
| ctl_valid | output | 1 | Upstream yield control flit valid |
| ctl_data | output | 16 | Upstream control flit contents |
| ctl_ready | input | 1 | Upstream accepts the control flit |

## Verification
The starvation trigger and the primary-priority decision can fall in the same cycle. In that cycle the counter arms a yield while a bypass flit still wins the output. The bench provokes this with an unbroken stream of single-flit bypass packets while one non-primary flit waits. It then checks that the bypass flit still owns the output in the trigger cycle, that the queued flit and the control flit both appear in the very next cycle with byp_ready low, and that the bypass side regains the link one cycle later.

// File: rtl/yarb_pkg.sv
package yarb_pkg;

    localparam int FLIT_DW   = 16;
    localparam int OPC_W     = 4;
    localparam logic [OPC_W-1:0] OPC_YIELD = 4'hA;

    typedef struct packed {
        logic               last;
        logic [FLIT_DW-1:0] data;
    } flit_t;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_PRI  = 2'd1,
        OWN_NP   = 2'd2
    } owner_e;

    // Decision taken only at a packet boundary.
    function automatic owner_e pick_owner(input logic yield_on,
                                          input logic pri_req,
                                          input logic np_req);
        if (yield_on && np_req) return OWN_NP;
        if (pri_req)            return OWN_PRI;
        if (np_req)             return OWN_NP;
        return OWN_NONE;
    endfunction

    function automatic logic [FLIT_DW-1:0] yield_flit();
        return {OPC_YIELD, {(FLIT_DW-OPC_W){1'b0}}};
    endfunction

endpackage

// File: rtl/yarb_np_fifo.sv
module yarb_np_fifo
    import yarb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  flit_t din,
    input  logic  pop,
    output flit_t dout,
    output logic  full,
    output logic  empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    flit_t        mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   cnt_q;

    assign full  = (int'(cnt_q) == DEPTH);
    assign empty = (cnt_q == '0);
    assign dout  = mem[rd_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push && !full) begin
                mem[wr_q] <= din;
                wr_q      <= bump(wr_q);
            end
            if (pop && !empty) rd_q <= bump(rd_q);
            case ({push && !full, pop && !empty})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/yarb_grant.sv
module yarb_grant
    import yarb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   yield_on,
    input  logic   pri_valid,
    input  flit_t  pri_flit,
    output logic   pri_ready,
    input  logic   np_valid,
    input  flit_t  np_flit,
    output logic   np_pop,
    output logic   np_tail_done,
    output logic   out_valid,
    output flit_t  out_flit,
    input  logic   out_ready,
    output owner_e owner,
    output logic   busy
);
    owner_e state_q;
    logic   xfer;

    assign busy = (state_q != OWN_NONE);

    always_comb begin
        owner = busy ? state_q : pick_owner(yield_on, pri_valid, np_valid);
        case (owner)
            OWN_PRI: begin out_valid = pri_valid; out_flit = pri_flit; end
            OWN_NP:  begin out_valid = np_valid;  out_flit = np_flit;  end
            default: begin out_valid = 1'b0;      out_flit = '0;       end
        endcase
    end

    assign xfer         = out_valid && out_ready;
    assign pri_ready    = (owner == OWN_PRI) && out_ready;
    assign np_pop       = (owner == OWN_NP) && xfer;
    assign np_tail_done = np_pop && np_flit.last;

    always_ff @(posedge clk) begin
        if (rst)       state_q <= OWN_NONE;
        else if (xfer) state_q <= out_flit.last ? OWN_NONE : owner;
    end
endmodule

// File: rtl/yarb_starve.sv
module yarb_starve
    import yarb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   thresh,
    input  logic               np_waiting,
    input  logic               np_granted,
    input  logic               np_tail_done,
    input  logic               ctl_ready,
    output logic               yield_on,
    output logic               ctl_valid,
    output logic [FLIT_DW-1:0] ctl_data
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic             starving, trip;

    assign starving = np_waiting && !np_granted;
    assign cnt_inc  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign trip     = starving && !yield_on && (cnt_inc >= {1'b0, thresh});
    assign ctl_data = yield_flit();

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            yield_on  <= 1'b0;
            ctl_valid <= 1'b0;
        end else begin
            if (!starving)         cnt_q <= '0;
            else if (cnt_q != '1)  cnt_q <= cnt_inc[CNT_W-1:0];

            if (ctl_valid && ctl_ready) ctl_valid <= 1'b0;

            if (yield_on && np_tail_done) begin
                yield_on <= 1'b0;
            end else if (trip) begin
                yield_on  <= 1'b1;
                ctl_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/yarb_top.sv
module yarb_top
    import yarb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   thresh,
    input  logic               byp_valid,
    input  logic [FLIT_DW-1:0] byp_data,
    input  logic               byp_last,
    output logic               byp_ready,
    input  logic               dir_valid,
    input  logic [FLIT_DW-1:0] dir_data,
    input  logic               dir_last,
    output logic               dir_ready,
    output logic               out_valid,
    output logic [FLIT_DW-1:0] out_data,
    output logic               out_last,
    input  logic               out_ready,
    output logic               ctl_valid,
    output logic [FLIT_DW-1:0] ctl_data,
    input  logic               ctl_ready
);
    flit_t  np_head, out_flit;
    logic   q_full, q_empty, np_pop, np_tail_done, yield_on, busy;
    owner_e owner;

    assign dir_ready = !q_full;
    assign out_data  = out_flit.data;
    assign out_last  = out_flit.last;

    yarb_np_fifo #(.DEPTH(DEPTH)) u_q (
        .clk(clk), .rst(rst),
        .push(dir_valid), .din('{last: dir_last, data: dir_data}),
        .pop(np_pop), .dout(np_head), .full(q_full), .empty(q_empty)
    );

    yarb_grant u_grant (
        .clk(clk), .rst(rst), .yield_on(yield_on),
        .pri_valid(byp_valid), .pri_flit('{last: byp_last, data: byp_data}),
        .pri_ready(byp_ready),
        .np_valid(!q_empty), .np_flit(np_head), .np_pop(np_pop),
        .np_tail_done(np_tail_done),
        .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready),
        .owner(owner), .busy(busy)
    );

    yarb_starve #(.CNT_W(CNT_W)) u_starve (
        .clk(clk), .rst(rst), .thresh(thresh),
        .np_waiting(!q_empty), .np_granted(owner == OWN_NP),
        .np_tail_done(np_tail_done), .ctl_ready(ctl_ready),
        .yield_on(yield_on), .ctl_valid(ctl_valid), .ctl_data(ctl_data)
    );
endmodule

// File: rtl/yarb_chk.sv
module yarb_chk
    import yarb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic   clk,
    input logic   rst,
    input logic   byp_valid,
    input logic   byp_ready,
    input logic   dir_valid,
    input logic   dir_ready,
    input logic   out_valid,
    input logic   out_ready,
    input logic   out_last,
    input logic   ctl_valid,
    input logic   ctl_ready,
    input logic   yield_on,
    input logic   busy,
    input owner_e owner
);
    localparam int OW = $clog2(DEPTH) + 2;
    logic [OW-1:0] occ_q;

    always_ff @(posedge clk) begin
        if (rst) occ_q <= '0;
        else occ_q <= occ_q + OW'(dir_valid && dir_ready)
                            - OW'(out_valid && out_ready && owner == OWN_NP);
    end

    // R4
    hold_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=> (owner == $past(owner)));

    // R2
    primary_first_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !yield_on && byp_valid) |-> (byp_ready == out_ready));

    // R8
    yield_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (yield_on && !busy) |-> (!byp_ready && owner == OWN_NP));

    // R5
    full_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(occ_q) <= DEPTH) && ((int'(occ_q) == DEPTH) == !dir_ready));

    // R7
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid && !ctl_ready) |=> ctl_valid);
endmodule

bind yarb_top yarb_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .byp_valid(byp_valid), .byp_ready(byp_ready),
    .dir_valid(dir_valid), .dir_ready(dir_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_last(out_last), .ctl_valid(ctl_valid),
    .ctl_ready(ctl_ready), .yield_on(yield_on), .busy(busy), .owner(owner)
);

// File: tb/yarb_top_test.sv
module yarb_top_test;
    import yarb_pkg::*;

    logic clk = 1'b0, rst = 1'b1;
    logic [7:0] thresh = 8'd200;
    logic byp_valid = 0, byp_last = 0, dir_valid = 0, dir_last = 0;
    logic out_ready = 0, ctl_ready = 0;
    logic [15:0] byp_data = 0, dir_data = 0;
    logic byp_ready, dir_ready, out_valid, out_last, ctl_valid;
    logic [15:0] out_data, ctl_data;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    yarb_top uut (.*);

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1; byp_valid = 0; dir_valid = 0; out_ready = 0; ctl_ready = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic expect_out(input logic v, input logic [15:0] d, input string tag);
        chk(out_valid == v, tag, {15'd0, out_valid}, {15'd0, v});
        if (v) chk(out_data == d, tag, out_data, d);
    endtask

    // {np_pre, byp_valid, out_ready, exp_out_valid, exp_src[1:0]} src: 0 none, 1 bypass, 2 queue
    localparam logic [5:0] VEC [7] = '{
        6'b000_0_00, 6'b011_1_01, 6'b010_1_01, 6'b101_1_10,
        6'b111_1_01, 6'b110_1_01, 6'b100_1_10
    };

    initial begin
        // reset state, R9
        do_reset();
        #2;
        chk(!out_valid, "R9 out_valid", {15'd0, out_valid}, 16'd0);
        chk(!ctl_valid, "R9 ctl_valid", {15'd0, ctl_valid}, 16'd0);
        chk(dir_ready,  "R9 dir_ready", {15'd0, dir_ready}, 16'd1);

        // vector walk: single-cycle arbitration, R1 R2 R3
        for (int i = 0; i < 7; i++) begin
            logic [15:0] bd, dd, ed;
            logic eb;
            do_reset();
            bd = 16'hB000 + 16'(i);
            dd = 16'hD000 + 16'(i);
            if (VEC[i][5]) begin
                dir_valid = 1; dir_data = dd; dir_last = 1;
                @(negedge clk);
                dir_valid = 0;
            end
            byp_valid = VEC[i][4]; byp_data = bd; byp_last = 1;
            out_ready = VEC[i][3];
            #2;
            ed = (VEC[i][1:0] == 2'd1) ? bd : dd;
            eb = (VEC[i][1:0] == 2'd1) && VEC[i][3];
            expect_out(VEC[i][2], ed, $sformatf("R1/R2/R3 vec%0d out", i));
            chk(byp_ready == eb, $sformatf("R1/R2 vec%0d byp_ready", i), {15'd0, byp_ready}, {15'd0, eb});
            @(negedge clk);
        end

        // queue fill and order, R5 R3
        do_reset();
        for (int k = 0; k < 4; k++) begin
            dir_valid = 1; dir_data = 16'hC000 + 16'(k); dir_last = 1;
            #2;
            chk(dir_ready, "R5 ready before full", {15'd0, dir_ready}, 16'd1);
            @(negedge clk);
        end
        dir_valid = 0;
        #2;
        chk(!dir_ready, "R5 ready when full", {15'd0, dir_ready}, 16'd0);
        @(negedge clk);
        out_ready = 1;
        for (int k = 0; k < 4; k++) begin
            #2;
            expect_out(1'b1, 16'hC000 + 16'(k), "R5/R3 queue order");
            @(negedge clk);
        end
        #2;
        expect_out(1'b0, 16'h0, "R5 queue drained");
        chk(dir_ready, "R5 ready after drain", {15'd0, dir_ready}, 16'd1);
        @(negedge clk);

        // packet hold across a bubble, R4
        do_reset();
        thresh = 8'd200;
        dir_valid = 1; dir_data = 16'hD100; dir_last = 1;
        @(negedge clk);
        dir_valid = 0;
        out_ready = 1;
        byp_valid = 1; byp_data = 16'hB100; byp_last = 0;
        #2; expect_out(1'b1, 16'hB100, "R2 head wins");
        @(negedge clk);
        byp_valid = 0;
        #2; expect_out(1'b0, 16'h0, "R4 bubble holds grant");
        @(negedge clk);
        byp_valid = 1; byp_data = 16'hB101; byp_last = 1;
        #2; expect_out(1'b1, 16'hB101, "R4 tail from bypass");
        @(negedge clk);
        byp_valid = 0;
        #2; expect_out(1'b1, 16'hD100, "R3 queue after tail");
        @(negedge clk);

        // starvation trigger coincides with a primary grant, R6 R7 R8
        do_reset();
        thresh = 8'd4;
        out_ready = 1;
        dir_valid = 1; dir_data = 16'hD200; dir_last = 1;
        byp_valid = 1; byp_last = 1; byp_data = 16'hB200;
        #2; expect_out(1'b1, 16'hB200, "R2 cycle1");
        @(negedge clk);
        dir_valid = 0;
        for (int c = 2; c <= 5; c++) begin
            byp_data = 16'hB200 + 16'(c);
            #2;
            expect_out(1'b1, byp_data, $sformatf("R6 bypass still wins c%0d", c));
            chk(!ctl_valid, "R6 no early yield", {15'd0, ctl_valid}, 16'd0);
            @(negedge clk);
        end
        byp_data = 16'hB206;
        #2;
        expect_out(1'b1, 16'hD200, "R8 queue during yield");
        chk(!byp_ready, "R8 bypass stalled", {15'd0, byp_ready}, 16'd0);
        chk(ctl_valid, "R7 ctl raised", {15'd0, ctl_valid}, 16'd1);
        chk(ctl_data == 16'hA000, "R7 ctl contents", ctl_data, 16'hA000);
        @(negedge clk);
        #2;
        chk(ctl_valid, "R7 ctl held", {15'd0, ctl_valid}, 16'd1);
        expect_out(1'b1, 16'hB206, "R8 bypass resumes");
        chk(byp_ready, "R8 bypass ready again", {15'd0, byp_ready}, 16'd1);
        @(negedge clk);
        ctl_ready = 1;
        @(negedge clk);
        #2;
        chk(!ctl_valid, "R7 ctl cleared", {15'd0, ctl_valid}, 16'd0);
        @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule